// File: doc/BRIEF.md
# PCIe Endpoint Type 0 Configuration Header

This block is the register file behind the Type 0 configuration header of one PCIe endpoint function. Configuration requests, already decoded by the transaction layer, reach it as dword accesses. Each access carries a 10-bit dword address, four byte enables and 32 bits of write data. A read returns its data one clock later, together with a single-cycle valid strobe.

The header keeps only the registers that still matter on a serial link. These are the Command and Status pair, Cache Line Size, and one 64-bit memory BAR that spans two consecutive slots. Control and status bits inherited from the parallel bus read back at fixed values, and writes cannot change them. The Latency Timer and the arbitration bytes read as zero. The BAR window is a parameterized power of two of at least 128 bytes. Software finds its size by writing all ones to the BAR and reading back which address bits stick.

Top module: `pcie_ep_cfg_header`

## Requirements
- R1: A read request (`cfg_req`=1, `cfg_we`=0) raises `cfg_rvalid` for exactly the following cycle, with the dword on `cfg_rdata`. At all other times `cfg_rvalid` is 0 and `cfg_rdata` is 0, and writes never raise `cfg_rvalid`.
- R2: Dword 1 bits 15:0 (command) reset to 0. Only bits 1, 2, 6, 8 and 10 are writable. Bits 0, 3, 4, 5, 7, 9 and 11–15 always read 0, whatever is written.
- R3: `mem_space_en` follows command bit 1 and `bus_master_en` follows command bit 2, both taking the written value on the clock edge that performs the write.
- R4: Dword 1 bits 31:16 (status) read 0x0010: the capability-list bit (bit 20 of the dword) is 1, bits 21, 23, 25 and 26 and all other status bits are 0, and writes do not change them.
- R5: Dword 3 byte 0 (cache line size) is read/write and resets to 0. Byte 1 (latency timer) and bytes 2–3 always read 0.
- R6: Dword 15 reads 0 in all bytes, including the minimum-grant and maximum-latency bytes 2 and 3, and writes to it are discarded.
- R7: Dword 4 bits 3:0 read {PREFETCHABLE, 1, 0, 0}. That is, bit 0 = 0 (memory), bits 2:1 = 2'b10 (64-bit decode), and bit 3 = the PREFETCHABLE parameter, to be set only for a range with no read side effects that tolerates write merging. BAR_SIZE_LOG2 below 7 or above 63 fails elaboration.
- R8: Dwords 4 and 5 hold the low and high halves of the BAR base. They reset to 0, and the address bits below 2^BAR_SIZE_LOG2 always read 0. Writing 0xFFFFFFFF to both halves therefore reads back the size mask (0xFFFFF00C and 0xFFFFFFFF for a 4 KiB prefetchable window).
- R9: A write changes only the byte lanes whose `cfg_be` bit is 1 (bit n enables bits 8n+7:8n).
- R10: Every dword address other than 1, 3, 4 and 5 reads 0, and a write to such an address changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_req | input | 1 | Access strobe, one access per cycle |
| cfg_we | input | 1 | 1 = write, 0 = read |
| cfg_dw_addr | input | 10 | Dword address within the 4 KiB configuration space |
| cfg_be | input | 4 | Byte-lane enables for writes |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data, valid with `cfg_rvalid` |
| cfg_rvalid | output | 1 | One-cycle read-data strobe |
| mem_space_en | output | 1 | Command memory-space enable |
| bus_master_en | output | 1 | Command bus-master enable |

## Verification
The assertions assume that every input is a known value at each clock edge, that at most one access is presented per cycle, and that `cfg_we` and `cfg_be` are only meaningful while `cfg_req` is high. The bench drives all inputs on the falling edge, holds `rst` high from time zero, and mixes idle cycles, byte-lane-masked writes and accesses to unmapped dwords. Random address choice is weighted toward the five implemented dwords, so every hardwired field is read many times after arbitrary write data.

// File: rtl/pcie_cfg_hdr_pkg.sv
package pcie_cfg_hdr_pkg;

    localparam int CFG_DW_W   = 10;
    localparam int CFG_DATA_W = 32;
    localparam int CFG_BE_W   = CFG_DATA_W / 8;

    typedef logic [CFG_DW_W-1:0]   cfg_dw_t;
    typedef logic [CFG_DATA_W-1:0] cfg_word_t;
    typedef logic [CFG_BE_W-1:0]   cfg_be_t;

    // Decoded access into the header
    typedef struct packed {
        logic      wr_cmd;
        logic      wr_cls;
        logic      wr_bar_lo;
        logic      wr_bar_hi;
        cfg_be_t   be;
        cfg_word_t data;
    } hdr_wr_t;

    // Dword slots with behaviour
    localparam cfg_dw_t DW_CMD_STS = cfg_dw_t'(1);
    localparam cfg_dw_t DW_CLS_LT  = cfg_dw_t'(3);
    localparam cfg_dw_t DW_BAR_LO  = cfg_dw_t'(4);
    localparam cfg_dw_t DW_BAR_HI  = cfg_dw_t'(5);
    localparam cfg_dw_t DW_INT_ARB = cfg_dw_t'(15);

    // Command bits kept: memory enable, bus master, parity resp, SERR enable, INTx disable
    localparam logic [15:0] CMD_RW_MASK = 16'h0546;
    // Status: only the capability-list bit is set
    localparam logic [15:0] STS_FIXED   = 16'h0010;

    function automatic cfg_word_t lane_merge(input cfg_word_t old_w,
                                             input cfg_word_t new_w,
                                             input cfg_be_t   be);
        cfg_word_t r;
        r = old_w;
        for (int i = 0; i < CFG_BE_W; i++) begin
            if (be[i]) r[8*i +: 8] = new_w[8*i +: 8];
        end
        return r;
    endfunction

endpackage

// File: rtl/pcie_cfg_cmd_reg.sv
module pcie_cfg_cmd_reg
    import pcie_cfg_hdr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  hdr_wr_t     wr,
    output logic [15:0] cmd_q,
    output logic [7:0]  cls_q
);

    cfg_word_t cmd_merged;
    cfg_word_t cls_merged;

    always_comb begin
        cmd_merged = lane_merge({16'd0, cmd_q}, wr.data, wr.be);
        cls_merged = lane_merge({24'd0, cls_q}, wr.data, wr.be);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q <= '0;
            cls_q <= '0;
        end else begin
            if (wr.wr_cmd) cmd_q <= cmd_merged[15:0] & CMD_RW_MASK;
            if (wr.wr_cls) cls_q <= cls_merged[7:0];
        end
    end

    AST_CMD_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cmd_q == 16'd0 && cls_q == 8'd0)) else $error("cmd reset"); // R2

    AST_CMD_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        !$past(wr.wr_cmd) |-> $stable(cmd_q)) else $error("cmd changed"); // R10

    AST_CLS_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        !$past(wr.wr_cls) |-> $stable(cls_q)) else $error("cls changed"); // R10

endmodule

// File: rtl/pcie_cfg_bar64.sv
module pcie_cfg_bar64
    import pcie_cfg_hdr_pkg::*;
#(
    parameter int BAR_SIZE_LOG2 = 12,
    parameter bit PREFETCHABLE  = 1'b1
) (
    input  logic      clk,
    input  logic      rst,
    input  hdr_wr_t   wr,
    output cfg_word_t lo_rd,
    output cfg_word_t hi_rd
);

    localparam logic [63:0] SPAN_M1   = (64'd1 << BAR_SIZE_LOG2) - 64'd1;
    localparam logic [63:0] ADDR_MASK = ~SPAN_M1;
    localparam logic [3:0]  ATTR      = {PREFETCHABLE, 2'b10, 1'b0};

    generate
        if (BAR_SIZE_LOG2 < 7 || BAR_SIZE_LOG2 > 63) begin : g_bad_size
            $error("BAR window must be 2^7 to 2^63 bytes");
        end
    endgenerate

    logic [63:0] base_q;
    logic [63:0] base_nxt;

    always_comb begin
        base_nxt = base_q;
        if (wr.wr_bar_lo) base_nxt[31:0]  = lane_merge(base_q[31:0],  wr.data, wr.be);
        if (wr.wr_bar_hi) base_nxt[63:32] = lane_merge(base_q[63:32], wr.data, wr.be);
    end

    always_ff @(posedge clk) begin
        if (rst) base_q <= '0;
        else     base_q <= base_nxt & ADDR_MASK;
    end

    assign lo_rd = {base_q[31:4], ATTR};
    assign hi_rd = base_q[63:32];

    AST_BAR_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (lo_rd[31:4] == 28'd0 && hi_rd == 32'd0)) else $error("bar reset"); // R8

    AST_BAR_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        !$past(wr.wr_bar_lo || wr.wr_bar_hi) |-> ($stable(lo_rd) && $stable(hi_rd))) else $error("bar changed"); // R10

endmodule

// File: rtl/pcie_ep_cfg_header.sv
module pcie_ep_cfg_header
    import pcie_cfg_hdr_pkg::*;
#(
    parameter int BAR_SIZE_LOG2 = 12,
    parameter bit PREFETCHABLE  = 1'b1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_req,
    input  logic        cfg_we,
    input  logic [9:0]  cfg_dw_addr,
    input  logic [3:0]  cfg_be,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    output logic        cfg_rvalid,
    output logic        mem_space_en,
    output logic        bus_master_en
);

    localparam logic [63:0] BAR_SPAN_M1 = (64'd1 << BAR_SIZE_LOG2) - 64'd1;
    localparam logic [31:0] BAR_LO_ZERO = BAR_SPAN_M1[31:0] & 32'hFFFF_FFF0;
    localparam logic [31:0] CMD_ZERO    = {16'd0, ~CMD_RW_MASK};

    hdr_wr_t   wr;
    logic [15:0] cmd_q;
    logic [7:0]  cls_q;
    cfg_word_t bar_lo, bar_hi;
    cfg_word_t rd_mux;
    logic      rd_go;
    cfg_dw_t   rd_dw_q;

    always_comb begin
        logic do_wr;
        do_wr        = cfg_req && cfg_we;
        wr.wr_cmd    = do_wr && (cfg_dw_addr == DW_CMD_STS);
        wr.wr_cls    = do_wr && (cfg_dw_addr == DW_CLS_LT);
        wr.wr_bar_lo = do_wr && (cfg_dw_addr == DW_BAR_LO);
        wr.wr_bar_hi = do_wr && (cfg_dw_addr == DW_BAR_HI);
        wr.be        = cfg_be;
        wr.data      = cfg_wdata;
    end

    assign rd_go = cfg_req && !cfg_we;

    pcie_cfg_cmd_reg u_cmd (
        .clk   (clk),
        .rst   (rst),
        .wr    (wr),
        .cmd_q (cmd_q),
        .cls_q (cls_q)
    );

    pcie_cfg_bar64 #(
        .BAR_SIZE_LOG2 (BAR_SIZE_LOG2),
        .PREFETCHABLE  (PREFETCHABLE)
    ) u_bar (
        .clk   (clk),
        .rst   (rst),
        .wr    (wr),
        .lo_rd (bar_lo),
        .hi_rd (bar_hi)
    );

    always_comb begin
        case (cfg_dw_addr)
            DW_CMD_STS: rd_mux = {STS_FIXED, cmd_q};
            DW_CLS_LT:  rd_mux = {24'd0, cls_q};
            DW_BAR_LO:  rd_mux = bar_lo;
            DW_BAR_HI:  rd_mux = bar_hi;
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_rvalid <= 1'b0;
            cfg_rdata  <= '0;
            rd_dw_q    <= '0;
        end else begin
            cfg_rvalid <= rd_go;
            cfg_rdata  <= rd_go ? rd_mux : '0;
            if (rd_go) rd_dw_q <= cfg_dw_addr;
        end
    end

    assign mem_space_en  = cmd_q[1];
    assign bus_master_en = cmd_q[2];

    AST_RVALID_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
        cfg_rvalid |-> $past(cfg_req && !cfg_we)) else $error("stray rvalid"); // R1

    AST_RDATA_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !cfg_rvalid |-> cfg_rdata == 32'd0) else $error("idle rdata"); // R1

    AST_CMD_OBSOLETE_ZERO: assert property (@(posedge clk) disable iff (rst)
        (cfg_rvalid && rd_dw_q == DW_CMD_STS) |-> (cfg_rdata & CMD_ZERO) == 32'd0) else $error("cmd bits"); // R2

    AST_STATUS_FIXED: assert property (@(posedge clk) disable iff (rst)
        (cfg_rvalid && rd_dw_q == DW_CMD_STS) |-> cfg_rdata[31:16] == 16'h0010) else $error("status"); // R4

    AST_LAT_TIMER_ZERO: assert property (@(posedge clk) disable iff (rst)
        (cfg_rvalid && rd_dw_q == DW_CLS_LT) |-> cfg_rdata[31:8] == 24'd0) else $error("lat timer"); // R5

    AST_ARB_BYTES_ZERO: assert property (@(posedge clk) disable iff (rst)
        (cfg_rvalid && rd_dw_q == DW_INT_ARB) |-> cfg_rdata == 32'd0) else $error("arb bytes"); // R6

    AST_BAR_ATTR: assert property (@(posedge clk) disable iff (rst)
        (cfg_rvalid && rd_dw_q == DW_BAR_LO) |-> cfg_rdata[3:0] == {PREFETCHABLE, 3'b100}) else $error("bar attr"); // R7

    AST_BAR_SIZE_BITS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (cfg_rvalid && rd_dw_q == DW_BAR_LO) |-> (cfg_rdata & BAR_LO_ZERO) == 32'd0) else $error("bar low bits"); // R8

    AST_MEM_EN_TRACKS_CMD: assert property (@(posedge clk) disable iff (rst)
        $past(wr.wr_cmd && cfg_be[0]) |-> mem_space_en == $past(cfg_wdata[1])) else $error("mem en"); // R3

endmodule

// File: tb/tb_pcie_ep_cfg_header.sv
`timescale 1ns/1ps
module tb_pcie_ep_cfg_header;

    localparam int SZ = 12;
    localparam bit PF = 1'b1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_req = 1'b0;
    logic        cfg_we = 1'b0;
    logic [9:0]  cfg_dw_addr = '0;
    logic [3:0]  cfg_be = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        cfg_rvalid;
    logic        mem_space_en;
    logic        bus_master_en;

    int n_chk = 0;
    int n_bad = 0;
    bit checking = 1'b0;

    always #2.5 clk = ~clk;

    pcie_ep_cfg_header #(.BAR_SIZE_LOG2(SZ), .PREFETCHABLE(PF)) dut (
        .clk(clk), .rst(rst), .cfg_req(cfg_req), .cfg_we(cfg_we),
        .cfg_dw_addr(cfg_dw_addr), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .cfg_rvalid(cfg_rvalid),
        .mem_space_en(mem_space_en), .bus_master_en(bus_master_en)
    );

    // Behavioural reference model
    logic [15:0] m_cmd;
    logic [7:0]  m_cls;
    logic [63:0] m_bar;
    logic        exp_rvalid;
    logic [31:0] exp_rdata;
    string       exp_tag;

    function automatic logic [31:0] merge(input logic [31:0] o, input logic [31:0] n, input logic [3:0] be);
        logic [31:0] r = o;
        for (int i = 0; i < 4; i++) if (be[i]) r[8*i +: 8] = n[8*i +: 8];
        return r;
    endfunction

    function automatic logic [31:0] model_read(input int dw);
        case (dw)
            1: return {16'h0010, m_cmd};
            3: return {24'd0, m_cls};
            4: return {m_bar[31:4], PF, 3'b100};
            5: return m_bar[63:32];
            default: return 32'd0;
        endcase
    endfunction

    function automatic string tag_of(input int dw);
        case (dw)
            1: return "R2 R4";
            3: return "R5";
            4: return "R7 R8";
            5: return "R8";
            15: return "R6";
            default: return "R10";
        endcase
    endfunction

    always @(posedge clk) begin
        logic [63:0] mask;
        mask = ~((64'd1 << SZ) - 64'd1);
        if (rst) begin
            m_cmd = '0; m_cls = '0; m_bar = '0;
            exp_rvalid = 1'b0; exp_rdata = '0; exp_tag = "R1";
        end else begin
            exp_rvalid = cfg_req && !cfg_we;
            exp_rdata  = exp_rvalid ? model_read(int'(cfg_dw_addr)) : 32'd0;
            exp_tag    = exp_rvalid ? tag_of(int'(cfg_dw_addr)) : "R1";
            if (cfg_req && cfg_we) begin
                case (int'(cfg_dw_addr))
                    1: m_cmd = merge({16'd0, m_cmd}, cfg_wdata, cfg_be) & 16'h0546;
                    3: m_cls = merge({24'd0, m_cls}, cfg_wdata, cfg_be) & 8'hFF;
                    4: m_bar = {m_bar[63:32], merge(m_bar[31:0], cfg_wdata, cfg_be)} & mask;
                    5: m_bar = {merge(m_bar[63:32], cfg_wdata, cfg_be), m_bar[31:0]} & mask;
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%08h expected=%08h at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (checking) begin
            chk(cfg_rvalid == exp_rvalid, "R1", {31'd0, cfg_rvalid}, {31'd0, exp_rvalid});
            chk(cfg_rdata == exp_rdata, exp_tag, cfg_rdata, exp_rdata);
            chk(mem_space_en == m_cmd[1], "R3", {31'd0, mem_space_en}, {31'd0, m_cmd[1]});
            chk(bus_master_en == m_cmd[2], "R3", {31'd0, bus_master_en}, {31'd0, m_cmd[2]});
        end
    end

    task automatic op(input bit we, input int dw, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        cfg_req = 1'b1; cfg_we = we; cfg_dw_addr = 10'(dw); cfg_be = be; cfg_wdata = d;
        @(posedge clk);
        #0.5;
        cfg_req = 1'b0; cfg_we = 1'b0;
    endtask

    task automatic rd_check(input int dw, input logic [31:0] exp, input string tag);
        op(1'b0, dw, 4'h0, 32'd0);
        @(negedge clk);
        #0.1;
        chk(cfg_rvalid === 1'b1 && cfg_rdata === exp, tag, cfg_rdata, exp);
    endtask

    initial begin
        #750000;
        n_bad++;
        $display("FAIL watchdog R1 actual=%08h expected=%08h", 32'd0, 32'd1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        checking = 1'b1;

        // reset state
        rd_check(1, 32'h0010_0000, "R2 R4");
        rd_check(3, 32'h0000_0000, "R5");
        rd_check(4, 32'h0000_000C, "R7 R8");
        rd_check(5, 32'h0000_0000, "R8");
        rd_check(15, 32'h0000_0000, "R6");

        // command / status
        op(1'b1, 1, 4'hF, 32'hFFFF_FFFF);
        rd_check(1, 32'h0010_0546, "R2 R4");
        chk(mem_space_en && bus_master_en, "R3", {30'd0, bus_master_en, mem_space_en}, 32'd3);
        op(1'b1, 1, 4'b0010, 32'h0000_0000);
        rd_check(1, 32'h0010_0046, "R9");
        op(1'b1, 1, 4'b0001, 32'h0000_0000);
        chk(!mem_space_en && !bus_master_en, "R3", {30'd0, bus_master_en, mem_space_en}, 32'd0);
        op(1'b1, 1, 4'hF, 32'h0000_0046);

        // cache line size, latency timer, arbitration bytes
        op(1'b1, 3, 4'hF, 32'hFFFF_FFFF);
        rd_check(3, 32'h0000_00FF, "R5");
        op(1'b1, 15, 4'hF, 32'hFFFF_FFFF);
        rd_check(15, 32'h0000_0000, "R6");

        // BAR sizing probe
        op(1'b1, 4, 4'hF, 32'hFFFF_FFFF);
        op(1'b1, 5, 4'hF, 32'hFFFF_FFFF);
        rd_check(4, 32'hFFFF_F00C, "R8");
        rd_check(5, 32'hFFFF_FFFF, "R8");
        op(1'b1, 4, 4'b0100, 32'h1234_5678);
        rd_check(4, 32'hFF34_F00C, "R9");

        // unimplemented offsets
        op(1'b1, 0, 4'hF, 32'hFFFF_FFFF);
        op(1'b1, 2, 4'hF, 32'hFFFF_FFFF);
        op(1'b1, 6, 4'hF, 32'hFFFF_FFFF);
        op(1'b1, 1023, 4'hF, 32'hFFFF_FFFF);
        rd_check(0, 32'h0, "R10");
        rd_check(6, 32'h0, "R10");
        rd_check(1023, 32'h0, "R10");
        rd_check(1, 32'h0010_0046, "R10");
        rd_check(4, 32'hFF34_F00C, "R10");

        // random traffic against the model
        for (int i = 0; i < 4000; i++) begin
            int pick;
            @(negedge clk);
            pick = int'($urandom_range(0, 11));
            cfg_req     = $urandom_range(0, 3) != 0;
            cfg_we      = $urandom_range(0, 1) == 1;
            cfg_be      = 4'($urandom);
            cfg_wdata   = $urandom;
            cfg_dw_addr = (pick < 7) ? 10'(pick) : (pick < 9) ? 10'd15 : 10'($urandom);
        end
        @(negedge clk);
        cfg_req = 1'b0;
        repeat (3) @(negedge clk);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule